// File: doc/BRIEF.md
# I2C Byte-Addressed EEPROM Target

This block is an I2C target that behaves like a 256-byte serial EEPROM whose word address is a single byte. It runs from a fast system clock and oversamples the bus lines through a synchronizer. A controller can write one byte or a run of bytes at a chosen address. It can read from the current address, or set the address with a dummy write and then read after a repeated START. Memory is a register file, and every cell holds its own address after reset.

The bus side has three pins. `scl_i` and `sda_i` are the line levels. `sda_pull_o` requests that the pad pull SDA low, so an open-drain pad is modelled without tristate logic. A 3-bit strap input sets the device address.

Two state machines share the work. The serial machine has six states:
- SER_IDLE: bus ignored.
- SER_RECV: shifting a byte in.
- SER_ACK_DRIVE: waiting for the SCL fall that starts the acknowledge.
- SER_ACK_HOLD: acknowledge held low until the next SCL fall.
- SER_SEND: shifting a byte out.
- SER_ACK_SAMPLE: reading the controller's answer.

START leads to SER_RECV from any state. STOP leads to SER_IDLE. SER_RECV moves to SER_ACK_DRIVE after the 8th bit, or to SER_IDLE if the device address does not match. SER_ACK_DRIVE moves to SER_ACK_HOLD. SER_ACK_HOLD moves to SER_RECV, or to SER_SEND when a read begins. SER_SEND moves to SER_ACK_SAMPLE after 8 bits. SER_ACK_SAMPLE moves back to SER_SEND on ACK, or to SER_IDLE on NACK.

The transaction machine steps through four phases:
- TXN_DEV: device-address byte.
- TXN_WADDR: pointer load.
- TXN_WDATA: data store.
- TXN_RDATA: data return.

START and STOP both reset it to TXN_DEV. TXN_DEV moves to TXN_WADDR on a write command and to TXN_RDATA on a read command. TXN_WADDR moves to TXN_WDATA. TXN_WDATA stays in TXN_WDATA for each further byte.

Top module: `i2c_eeprom_target`

## Requirements
- R1: A START is SDA falling while SCL is high. From any state, including partway through a transfer (repeated START), it makes the next byte a device-address byte, and the pointer is kept.
- R2: A STOP is SDA rising while SCL is high. It ends the transfer, releases SDA and returns to waiting for a START.
- R3: Received bits are sampled on SCL rising edges, MSB first. The target pulls SDA low from the first SCL fall after the 8th bit until the following SCL fall.
- R4: In the device-address byte, bits [3:1] must equal the strap and bit 0 selects read (1) or write (0). Bits [7:4] are not examined.
- R5: If bits [3:1] do not match the strap, there is no acknowledge. SDA stays released and all later bytes are ignored (memory unchanged) until START or STOP.
- R6: After a write command, the first byte loads the pointer. Each further byte is stored at the pointer, which then increments modulo 256.
- R7: A read command returns data from the current pointer without reloading it. Each bit is driven MSB first after an SCL fall, the first bit after the acknowledge fall. The pointer increments modulo 256 per byte sent, keeps its value across transfers, and more bytes follow while the controller ACKs.
- R8: A NACK from the controller after a read byte ends the transfer. SDA stays released until START or STOP.
- R9: After reset, cell i holds i, the pointer is 0 and SDA is released.
- R10: `sda_pull_o` never changes while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_strap_i | input | 3 | Device address select, compared with bits [3:1] |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_pull_o | output | 1 | 1 requests the pad to pull SDA low |

## Verification
The bench sets up a pointer with a dummy write and reads it back after a repeated START. A design that reloads or clears the pointer on START returns the wrong byte. Writes and reads cross the 0xFF to 0x00 boundary, and a later current-address read checks that the pointer kept its value. A design that does not wrap, or that resets the pointer between transfers, returns bytes from the wrong place. A mismatched device address is followed by bytes that would overwrite a known cell. A design that acknowledges anyway, or keeps storing data, shows up as an unexpected ACK or a changed cell. A bus monitor flags any change of the pull output while SCL is high, which catches a design that moves its data or acknowledge bit on the wrong edge.

// File: rtl/i2c_eep_pkg.sv
package i2c_eep_pkg;

    typedef enum logic [2:0] {
        SER_IDLE,
        SER_RECV,
        SER_ACK_DRIVE,
        SER_ACK_HOLD,
        SER_SEND,
        SER_ACK_SAMPLE
    } ser_state_t;

    typedef enum logic [1:0] {
        TXN_DEV,
        TXN_WADDR,
        TXN_WDATA,
        TXN_RDATA
    } txn_state_t;

    localparam int BYTE_W    = 8;
    localparam int BIT_CNT_W = 4;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_p;
    logic              sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_p    <= 1'b1;
            sda_p    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_p    <= scl_pipe[STAGES-1];
            sda_p    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/eep_store.sv
module eep_store #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= DW'(i);
            end
        end else if (we) begin
            cells[addr] <= wdata;
        end
    end

    assign rdata = cells[addr];

endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
    import i2c_eep_pkg::*;
#(
    parameter int MEM_AW      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] dev_strap_i,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_pull_o
);

    localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(BYTE_W - 1);
    localparam logic [BIT_CNT_W-1:0] FULL_CNT = BIT_CNT_W'(BYTE_W);

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    ser_state_t            ser_q, ser_d;
    txn_state_t            txn_q, txn_d;
    logic [BIT_CNT_W-1:0]  cnt_q, cnt_d;
    logic [BYTE_W-1:0]     sh_q, sh_d;
    logic [MEM_AW-1:0]     ptr_q, ptr_d;
    logic                  drv_q, drv_d;
    logic                  mem_we;
    logic [BYTE_W-1:0]     mem_rdata;

    eep_store #(.AW(MEM_AW), .DW(BYTE_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .addr  (ptr_q),
        .wdata (sh_q),
        .rdata (mem_rdata)
    );

    // next-state process
    always_comb begin
        ser_d  = ser_q;
        txn_d  = txn_q;
        cnt_d  = cnt_q;
        sh_d   = sh_q;
        ptr_d  = ptr_q;
        drv_d  = drv_q;
        mem_we = 1'b0;
        if (stop_det) begin
            ser_d = SER_IDLE;
            txn_d = TXN_DEV;
            drv_d = 1'b0;
        end else if (start_det) begin
            ser_d = SER_RECV;
            txn_d = TXN_DEV;
            cnt_d = '0;
            drv_d = 1'b0;
        end else begin
            unique case (ser_q)
                SER_IDLE: begin
                end
                SER_RECV: begin
                    if (scl_rise) begin
                        sh_d  = {sh_q[BYTE_W-2:0], sda_s};
                        cnt_d = cnt_q + 1'b1;
                        if (cnt_q == LAST_BIT) begin
                            if (txn_q == TXN_DEV && sh_q[2:0] != dev_strap_i) begin
                                ser_d = SER_IDLE;
                            end else begin
                                ser_d = SER_ACK_DRIVE;
                            end
                        end
                    end
                end
                SER_ACK_DRIVE: begin
                    if (scl_fall) begin
                        drv_d = 1'b1;
                        ser_d = SER_ACK_HOLD;
                    end
                end
                SER_ACK_HOLD: begin
                    if (scl_fall) begin
                        drv_d = 1'b0;
                        cnt_d = '0;
                        ser_d = SER_RECV;
                        unique case (txn_q)
                            TXN_DEV: begin
                                if (sh_q[0]) begin
                                    txn_d = TXN_RDATA;
                                    sh_d  = {mem_rdata[BYTE_W-2:0], 1'b0};
                                    drv_d = ~mem_rdata[BYTE_W-1];
                                    cnt_d = BIT_CNT_W'(1);
                                    ptr_d = ptr_q + 1'b1;
                                    ser_d = SER_SEND;
                                end else begin
                                    txn_d = TXN_WADDR;
                                end
                            end
                            TXN_WADDR: begin
                                ptr_d = MEM_AW'(sh_q);
                                txn_d = TXN_WDATA;
                            end
                            TXN_WDATA: begin
                                mem_we = 1'b1;
                                ptr_d  = ptr_q + 1'b1;
                            end
                            TXN_RDATA: begin
                                ser_d = SER_IDLE;
                            end
                        endcase
                    end
                end
                SER_SEND: begin
                    if (scl_fall) begin
                        if (cnt_q == FULL_CNT) begin
                            drv_d = 1'b0;
                            ser_d = SER_ACK_SAMPLE;
                        end else begin
                            drv_d = ~sh_q[BYTE_W-1];
                            sh_d  = {sh_q[BYTE_W-2:0], 1'b0};
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                end
                SER_ACK_SAMPLE: begin
                    if (scl_rise) begin
                        if (!sda_s) begin
                            sh_d  = mem_rdata;
                            ptr_d = ptr_q + 1'b1;
                            cnt_d = '0;
                            ser_d = SER_SEND;
                        end else begin
                            ser_d = SER_IDLE;
                        end
                    end
                end
            endcase
        end
    end

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ser_q <= SER_IDLE;
            txn_q <= TXN_DEV;
            cnt_q <= '0;
            sh_q  <= '0;
            ptr_q <= '0;
            drv_q <= 1'b0;
        end else begin
            ser_q <= ser_d;
            txn_q <= txn_d;
            cnt_q <= cnt_d;
            sh_q  <= sh_d;
            ptr_q <= ptr_d;
            drv_q <= drv_d;
        end
    end

    // output process
    always_comb begin
        sda_pull_o = drv_q;
    end

    AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !stop_det) |=> (ser_q == SER_RECV && txn_q == TXN_DEV)); // R1
    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (ser_q == SER_IDLE && !sda_pull_o)); // R2
    AST_ACK_HELD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_q == SER_ACK_HOLD) |-> sda_pull_o); // R3
    AST_BIT_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL_CNT); // R3
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_q == SER_IDLE) |-> !sda_pull_o); // R5
    AST_SDA_HOLD_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s)) |-> $stable(sda_pull_o)); // R10

endmodule

// File: tb/i2c_eeprom_target_bench.sv
module i2c_eeprom_target_bench;

    localparam time Q = 40ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic ctrl_pull = 1'b0;
    logic dut_pull;
    logic sda_bus;
    logic [2:0] strap = 3'b101;

    int checks = 0;
    int errs = 0;
    int hold_viol = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] obs_byte;
    event       obs_ev;

    localparam logic [7:0] DEV_W = 8'hAA;
    localparam logic [7:0] DEV_R = 8'hAB;

    always #2ns clk = ~clk;

    assign sda_bus = !(ctrl_pull || dut_pull);

    i2c_eeprom_target u_i2c_eeprom_target (
        .clk         (clk),
        .rst_n       (rst_n),
        .dev_strap_i (strap),
        .scl_i       (scl),
        .sda_i       (sda_bus),
        .sda_pull_o  (dut_pull)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // scoreboard monitor: pops the expected byte when a read byte completes
    initial begin
        forever begin
            @(obs_ev);
            if (exp_q.size() == 0) begin
                checks++;
                errs++;
                $display("FAIL R7 unexpected read byte: actual %0h expected none", obs_byte);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                chk(t, "read data", int'(obs_byte), int'(e));
            end
        end
    end

    // R10 bus monitor
    initial begin
        logic pscl = 1'b1;
        logic ppull = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && scl && pscl && (dut_pull !== ppull)) hold_viol++;
            pscl = scl;
            ppull = dut_pull;
        end
    end

    task automatic bus_start();
        #Q ctrl_pull = 1'b0;
        #Q scl = 1'b1;
        #Q ctrl_pull = 1'b1;
        #Q scl = 1'b0;
    endtask

    task automatic bus_stop();
        #Q ctrl_pull = 1'b1;
        #Q scl = 1'b1;
        #Q ctrl_pull = 1'b0;
        #Q;
        chk("R2", "SDA released after STOP", int'(dut_pull), 0);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked, output logic released);
        for (int i = 7; i >= 0; i--) begin
            #Q ctrl_pull = !b[i];
            #Q scl = 1'b1;
            #Q scl = 1'b0;
        end
        #Q ctrl_pull = 1'b0;
        #Q scl = 1'b1;
        #(Q/2) acked = !sda_bus;
        #(Q/2) scl = 1'b0;
        #(Q/2) released = !dut_pull;
    endtask

    task automatic tx(input logic [7:0] b, input logic exp_ack, input string req);
        logic a;
        logic r;
        send_byte(b, a, r);
        chk(req, $sformatf("ack for byte %02h", b), int'(a), int'(exp_ack));
    endtask

    task automatic tx_rel(input logic [7:0] b, input string req);
        logic a;
        logic r;
        send_byte(b, a, r);
        chk(req, $sformatf("ack for byte %02h", b), int'(a), 1);
        chk(req, "SDA released after ack fall", int'(r), 1);
    endtask

    task automatic rx(input logic [7:0] e, input logic ack_it, input string req);
        logic [7:0] b = '0;
        exp_q.push_back(e);
        tag_q.push_back(req);
        ctrl_pull = 1'b0;
        for (int i = 0; i < 8; i++) begin
            #Q;
            #Q scl = 1'b1;
            #(Q/2) b = {b[6:0], sda_bus};
            #(Q/2) scl = 1'b0;
        end
        #Q ctrl_pull = ack_it;
        #Q scl = 1'b1;
        #Q scl = 1'b0;
        #Q ctrl_pull = 1'b0;
        obs_byte = b;
        ->obs_ev;
        #1ns;
    endtask

    initial begin
        #(400us);
        checks++;
        errs++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    end

    initial begin
        #20ns rst_n = 1'b1;
        #80ns;
        chk("R9", "SDA released after reset", int'(dut_pull), 0);

        // R9/R7: current-address read from reset pointer 0
        bus_start();
        tx(DEV_R, 1'b1, "R4");
        rx(8'h00, 1'b1, "R9");
        rx(8'h01, 1'b1, "R7");
        rx(8'h02, 1'b0, "R8");
        chk("R8", "SDA released after NACK", int'(dut_pull), 0);
        bus_stop();

        // R6/R3: random write
        bus_start();
        tx(DEV_W, 1'b1, "R3");
        tx(8'h10, 1'b1, "R6");
        tx_rel(8'h5A, "R3");
        bus_stop();

        // R1: dummy write + repeated START + read
        bus_start();
        tx(DEV_W, 1'b1, "R4");
        tx(8'h10, 1'b1, "R6");
        bus_start();
        tx(DEV_R, 1'b1, "R1");
        rx(8'h5A, 1'b1, "R6");
        rx(8'h11, 1'b0, "R7");
        bus_stop();

        // R6/R7: wrap across 0xFF
        bus_start();
        tx(DEV_W, 1'b1, "R6");
        tx(8'hFE, 1'b1, "R6");
        tx(8'h11, 1'b1, "R6");
        tx(8'h22, 1'b1, "R6");
        tx(8'h33, 1'b1, "R6");
        bus_stop();
        bus_start();
        tx(DEV_W, 1'b1, "R6");
        tx(8'hFE, 1'b1, "R6");
        bus_start();
        tx(DEV_R, 1'b1, "R1");
        rx(8'h11, 1'b1, "R7");
        rx(8'h22, 1'b1, "R7");
        rx(8'h33, 1'b0, "R7");
        bus_stop();
        // pointer persists across transfers
        bus_start();
        tx(DEV_R, 1'b1, "R7");
        rx(8'h01, 1'b0, "R7");
        bus_stop();

        // R5: mismatched address ignored
        bus_start();
        tx(8'hA0, 1'b0, "R5");
        tx(8'h20, 1'b0, "R5");
        tx(8'h99, 1'b0, "R5");
        bus_stop();
        bus_start();
        tx(DEV_W, 1'b1, "R5");
        tx(8'h20, 1'b1, "R5");
        bus_start();
        tx(DEV_R, 1'b1, "R5");
        rx(8'h20, 1'b0, "R5");
        bus_stop();

        // R4: upper nibble not examined
        bus_start();
        tx(8'h1A, 1'b1, "R4");
        tx(8'h30, 1'b1, "R4");
        tx(8'h77, 1'b1, "R4");
        bus_stop();
        bus_start();
        tx(DEV_W, 1'b1, "R4");
        tx(8'h30, 1'b1, "R4");
        bus_start();
        tx(DEV_R, 1'b1, "R4");
        rx(8'h77, 1'b0, "R4");
        bus_stop();

        // R1: repeated START right after a data byte
        bus_start();
        tx(DEV_W, 1'b1, "R1");
        tx(8'h40, 1'b1, "R1");
        tx(8'hC3, 1'b1, "R1");
        bus_start();
        tx(DEV_R, 1'b1, "R1");
        rx(8'h41, 1'b0, "R1");
        bus_stop();

        #(4*Q);
        chk("R10", "pull changes while SCL high", hold_viol, 0);
        chk("R7", "scoreboard drained", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    end

endmodule